// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits beside a DDR SDRAM command path. It keeps the burst-related fields of the memory's mode register. For every read or write column command it produces, one beat per clock, the column addresses that the memory visits during the burst. A mode-register write is captured only when the bank-select bits address the main mode register. The block decodes three fields from that write: the burst length, whether the burst order is linear or XOR-based, and the read latency, which it reports in half-clock units.

A column command arrives as a start strobe with a 10-bit starting column. The column bits above the burst-length boundary fix an aligned block. The low bits give the first access, and every later access stays inside that block. A reserved code raises a configuration-error flag, and start strobes are then refused until a legal value is written. A start strobe that arrives during a running burst cuts that burst short and begins a new one.

Top module: `burst_col_seq`

## Requirements
- R1: A mode write (`mrsValid`=1) changes the configuration only when `mrsBank`=2'b00. With any other bank value the write leaves `casHalfCycles`, `casValid` and `cfgError` unchanged.
- R2: Address bits [2:0] select the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8.
- R3: Address bit [3] selects the order: 0 is sequential and 1 is interleaved.
- R4: Address bits [6:4] select the latency. 3'b010 gives `casHalfCycles`=4 (2 clocks) and 3'b110 gives 5 (2.5 clocks). Both take effect in the cycle after the write, with `casValid`=1.
- R5: A bank-0 write with a reserved burst-length code, a reserved latency code, or any of bits [12:9] or [7] set makes `cfgError`=1 and `casValid`=0 in the next cycle. A write with only bit [8] set among the high bits is accepted and clears `cfgError`.
- R6: While `casValid`=0, meaning after reset or after a rejected write, a start strobe starts no burst.
- R7: Sequential order: beat k outputs the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The upper bits stay those of the start column.
- R8: Interleaved order: beat k outputs the start column with its low log2(BL) bits replaced by (start low bits XOR k).
- R9: The first beat appears in the cycle after an accepted start, with one beat per cycle. `lastBeat` is 1 only on beat BL-1, and `beatValid` drops in the following cycle unless a new start is accepted.
- R10: An accepted start during a burst ends that burst at once. The next cycle shows beat 0 of the new burst.
- R11: After reset `beatValid`=0, `lastBeat`=0, `casValid`=0 and `cfgError`=0.
- R12: The length and order are captured when a burst starts. A mode write during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mrsValid | input | 1 | Mode-register write strobe |
| mrsAddr | input | 13 | Address bus value carried with the mode write |
| mrsBank | input | 2 | Bank-select value carried with the mode write |
| startValid | input | 1 | Column command (burst start) strobe |
| startCol | input | 10 | Starting column of the burst |
| colOut | output | 10 | Column address of the current beat |
| beatValid | output | 1 | A beat is being presented on `colOut` |
| lastBeat | output | 1 | Current beat is the final one of the burst |
| casHalfCycles | output | 3 | Decoded read latency in half clocks |
| casValid | output | 1 | A legal configuration is held |
| cfgError | output | 1 | Last bank-0 mode write was rejected |

## Verification
A wrong captured start column or a wrong order bit shows up on `colOut` no later than the second beat after the start. A wrong beat counter or a wrong captured length shows up as a misplaced `lastBeat`, or as a `beatValid` that ends early or late, within at most eight cycles. A wrong decode of a mode write is visible on `casHalfCycles`, `casValid` or `cfgError` in the cycle after the write. It is also visible on whether the next start strobe produces a beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // beat index width: longest burst is 8 beats
  localparam int BEAT_W = 3;
  localparam int LEN_W  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;    // capture a new start column
    logic [BEAT_W-1:0] beat;    // index of the beat in flight
    logic [LEN_W-1:0]  lenLog;  // log2 of the captured burst length
    logic              ilv;     // interleaved order when set
  } seqStrobe_t;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsValid,
  input  logic [ADDR_W-1:0] mrsAddr,
  input  logic [1:0]        mrsBank,
  input  logic              startValid,
  output seqStrobe_t        strb,
  output logic              beatValid,
  output logic              lastBeat,
  output logic [2:0]        casHalfCycles,
  output logic              casValid,
  output logic              cfgError
);
  localparam int HI_LO = 9;

  logic [LEN_W-1:0]  decLen;
  logic              lenOk, latOk, opOk, mrsHit, startAcc;
  logic [2:0]        decLat;
  logic [LEN_W-1:0]  cfgLen, curLen;
  logic              cfgIlv, curIlv, active;
  logic [BEAT_W-1:0] beat, lastIdx;

  // field decode of the mode write
  always_comb begin
    lenOk  = 1'b1;
    decLen = '0;
    case (mrsAddr[2:0])
      3'b001:  decLen = 2'd1;
      3'b010:  decLen = 2'd2;
      3'b011:  decLen = 2'd3;
      default: lenOk  = 1'b0;
    endcase
    latOk  = 1'b1;
    decLat = 3'd0;
    case (mrsAddr[6:4])
      3'b010:  decLat = 3'd4;
      3'b110:  decLat = 3'd5;
      default: latOk  = 1'b0;
    endcase
    opOk = (mrsAddr[ADDR_W-1:HI_LO] == '0) && !mrsAddr[7];
  end

  assign mrsHit   = mrsValid && (mrsBank == 2'b00);
  assign startAcc = startValid && casValid;
  assign lastIdx  = BEAT_W'((4'd1 << curLen) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      casValid      <= 1'b0;
      cfgError      <= 1'b0;
      cfgLen        <= '0;
      cfgIlv        <= 1'b0;
      casHalfCycles <= '0;
    end else if (mrsHit) begin
      if (lenOk && latOk && opOk) begin
        casValid      <= 1'b1;
        cfgError      <= 1'b0;
        cfgLen        <= decLen;
        cfgIlv        <= mrsAddr[3];
        casHalfCycles <= decLat;
      end else begin
        casValid <= 1'b0;
        cfgError <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      beat   <= '0;
      curLen <= 2'd1;
      curIlv <= 1'b0;
    end else if (startAcc) begin
      active <= 1'b1;
      beat   <= '0;
      curLen <= cfgLen;
      curIlv <= cfgIlv;
    end else if (active) begin
      if (beat == lastIdx) active <= 1'b0;
      else                 beat   <= beat + 1'b1;
    end
  end

  assign strb.load   = startAcc;
  assign strb.beat   = beat;
  assign strb.lenLog = curLen;
  assign strb.ilv    = curIlv;
  assign beatValid   = active;
  assign lastBeat    = active && (beat == lastIdx);

  a_r9_last_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);
  a_r9_start_first: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && casValid) |=> (beatValid && !lastBeat));
  a_r9_end_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startValid) |=> !beatValid);
  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !lastBeat) |=> beatValid);
  a_r6_refuse_start: assert property (@(posedge clk) disable iff (!rstN)
    (!casValid && !beatValid && startValid) |=> !beatValid);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(casValid && cfgError));
  a_r4_latency_range: assert property (@(posedge clk) disable iff (!rstN)
    casValid |-> (casHalfCycles == 3'd4 || casHalfCycles == 3'd5));
  a_r1_other_bank: assert property (@(posedge clk) disable iff (!rstN)
    (mrsValid && mrsBank != 2'b00) |=>
      ($stable(casHalfCycles) && $stable(casValid) && $stable(cfgError)));
endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] startCol,
  input  seqStrobe_t       strb,
  output logic [COL_W-1:0] colOut
);
  logic [COL_W-1:0] baseCol, lowMask, beatExt, offs;

  always_ff @(posedge clk) begin
    if (!rstN)          baseCol <= '0;
    else if (strb.load) baseCol <= startCol;
  end

  always_comb begin
    lowMask = COL_W'((32'd1 << strb.lenLog) - 32'd1);
    beatExt = COL_W'(strb.beat);
    offs    = strb.ilv ? (baseCol ^ beatExt) : (baseCol + beatExt);
    colOut  = (baseCol & ~lowMask) | (offs & lowMask);
  end

  a_r7_first_is_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (colOut == $past(startCol)));
  a_r7_block_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ((colOut & ~lowMask) == ($past(colOut) & ~$past(lowMask))));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsValid,
  input  logic [ADDR_W-1:0] mrsAddr,
  input  logic [1:0]        mrsBank,
  input  logic              startValid,
  input  logic [COL_W-1:0]  startCol,
  output logic [COL_W-1:0]  colOut,
  output logic              beatValid,
  output logic              lastBeat,
  output logic [2:0]        casHalfCycles,
  output logic              casValid,
  output logic              cfgError
);
  seqStrobe_t strb;

  bcs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsAddr(mrsAddr),
    .mrsBank(mrsBank), .startValid(startValid), .strb(strb),
    .beatValid(beatValid), .lastBeat(lastBeat),
    .casHalfCycles(casHalfCycles), .casValid(casValid), .cfgError(cfgError)
  );

  bcs_dpath #(.COL_W(COL_W)) uDp (
    .clk(clk), .rstN(rstN), .startCol(startCol), .strb(strb), .colOut(colOut)
  );
endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mrsValid = 1'b0;
  logic [12:0] mrsAddr = '0;
  logic [1:0]  mrsBank = '0;
  logic        startValid = 1'b0;
  logic [9:0]  startCol = '0;
  logic [9:0]  colOut;
  logic        beatValid, lastBeat, casValid, cfgError;
  logic [2:0]  casHalfCycles;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  burst_col_seq u0 (
    .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsAddr(mrsAddr),
    .mrsBank(mrsBank), .startValid(startValid), .startCol(startCol),
    .colOut(colOut), .beatValid(beatValid), .lastBeat(lastBeat),
    .casHalfCycles(casHalfCycles), .casValid(casValid), .cfgError(cfgError)
  );

  typedef struct packed {
    logic [12:0]      mode;
    logic [9:0]       start;
    logic [3:0]       len;
    logic [2:0]       cas;
    logic [0:7][9:0]  cols;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{13'h023, 10'h0D5, 4'd8, 3'd4,
      '{10'h0D5, 10'h0D6, 10'h0D7, 10'h0D0, 10'h0D1, 10'h0D2, 10'h0D3, 10'h0D4}},
    '{13'h06B, 10'h2A5, 4'd8, 3'd5,
      '{10'h2A5, 10'h2A4, 10'h2A7, 10'h2A6, 10'h2A1, 10'h2A0, 10'h2A3, 10'h2A2}},
    '{13'h022, 10'h3FE, 4'd4, 3'd4,
      '{10'h3FE, 10'h3FF, 10'h3FC, 10'h3FD, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{13'h06A, 10'h011, 4'd4, 3'd5,
      '{10'h011, 10'h010, 10'h013, 10'h012, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{13'h021, 10'h107, 4'd2, 3'd4,
      '{10'h107, 10'h106, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{13'h129, 10'h000, 4'd2, 3'd4,
      '{10'h000, 10'h001, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modeWrite(logic [12:0] a, logic [1:0] b);
    mrsAddr = a; mrsBank = b; mrsValid = 1'b1;
    tick();
    mrsValid = 1'b0;
  endtask

  task automatic startBurst(logic [9:0] c);
    startCol = c; startValid = 1'b1;
    tick();
    startValid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rstN = 1'b1;
    // R11 reset state
    chk("R11", "beatValid", beatValid, 0);
    chk("R11", "lastBeat", lastBeat, 0);
    chk("R11", "casValid", casValid, 0);
    chk("R11", "cfgError", cfgError, 0);
    // R6 start before any configuration
    startBurst(10'h055);
    chk("R6", "beatValid no config", beatValid, 0);

    // table walk: R2 R3 R4 R7 R8 R9
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      string ordTag = v.mode[3] ? "R8" : "R7";
      modeWrite(v.mode, 2'b00);
      chk("R4", "casValid", casValid, 1);
      chk("R4", "casHalfCycles", casHalfCycles, v.cas);
      startBurst(v.start);
      for (int k = 0; k < v.len; k++) begin
        chk("R9", "beatValid", beatValid, 1);
        chk(ordTag, "colOut", colOut, v.cols[k]);
        chk("R2", "lastBeat", lastBeat, (k == v.len - 1) ? 1 : 0);
        tick();
      end
      chk("R9", "idle after last", beatValid, 0);
    end

    // R1 writes to other banks are ignored (current cas = 4)
    modeWrite(13'h063, 2'b01);
    chk("R1", "casHalfCycles", casHalfCycles, 4);
    chk("R1", "casValid", casValid, 1);
    modeWrite(13'h000, 2'b10);
    chk("R1", "cfgError", cfgError, 0);
    chk("R1", "casValid", casValid, 1);

    // R12 config change during burst; R10 truncation
    modeWrite(13'h023, 2'b00);
    startBurst(10'h008);
    chk("R12", "beat0", colOut, 10'h008);
    modeWrite(13'h021, 2'b00);
    chk("R12", "beat1", colOut, 10'h009);
    tick();
    chk("R12", "beat2 valid", beatValid, 1);
    chk("R12", "beat2 col", colOut, 10'h00A);
    chk("R12", "beat2 not last", lastBeat, 0);
    startBurst(10'h01E);
    chk("R10", "restart beat0", colOut, 10'h01E);
    chk("R10", "restart not last", lastBeat, 0);
    tick();
    chk("R10", "restart beat1", colOut, 10'h01F);
    chk("R10", "restart last", lastBeat, 1);
    tick();
    chk("R10", "restart idle", beatValid, 0);

    // R5 reserved codes and R6 refusal
    modeWrite(13'h020, 2'b00);
    chk("R5", "cfgError bl", cfgError, 1);
    chk("R5", "casValid bl", casValid, 0);
    startBurst(10'h004);
    chk("R6", "beatValid after error", beatValid, 0);
    modeWrite(13'h022, 2'b00);
    chk("R5", "recover", cfgError, 0);
    modeWrite(13'h013, 2'b00);
    chk("R5", "cfgError cl", cfgError, 1);
    modeWrite(13'h022, 2'b00);
    modeWrite(13'h223, 2'b00);
    chk("R5", "cfgError a9", cfgError, 1);
    modeWrite(13'h022, 2'b00);
    modeWrite(13'h0A3, 2'b00);
    chk("R5", "cfgError a7", cfgError, 1);
    modeWrite(13'h122, 2'b00);
    chk("R5", "a8 accepted err", cfgError, 0);
    chk("R5", "a8 accepted valid", casValid, 1);
    startBurst(10'h3FF);
    chk("R7", "wrap beat0", colOut, 10'h3FF);
    tick();
    chk("R7", "wrap beat1", colOut, 10'h3FC);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule